// File: doc/BRIEF.md
# Sixteen-Bit Flag-Producing ALU

This block is the arithmetic and logic stage of a small accumulator-style processor. Each cycle it takes a 6-bit operation code, a destination operand, a source operand and the current condition flags. The flags are carry, zero, sign and overflow. From these it computes a result word, a write-back enable and a new set of flags. A per-flag update mask shows which flags the operation defined. The supported operations are:

- add, subtract and compare;
- bitwise AND, OR and XOR, and a bitwise test;
- two's-complement negate and one's-complement invert.

Compare and test set flags only and request no write-back.

The datapath itself is combinational. All outputs pass through one output register stage with a synchronous active-high reset, so results appear one clock after their inputs. Any flag that an operation leaves alone is passed through unchanged from `flags_in` to `flags_out`. The sequencer can therefore always load `flags_out` into its flag register.

Top module: `flag_alu`

## Requirements
- R1: Outputs are registered. The values driven on the inputs at a rising clock edge appear on all outputs after that edge and stay until the next edge. Operation codes: 0x02 add, 0x03 subtract, 0x04 AND, 0x05 OR, 0x0B test, 0x0C compare, 0x19 negate, 0x1D invert, 0x26 XOR. Flag vectors use bit 3 carry, bit 2 zero, bit 1 sign, bit 0 overflow.
- R2: While `rst` is high at a clock edge, `result_out`, `wr_en`, `flags_out` and `flag_upd` become 0.
- R3: Add produces dst+src modulo 2^16. Carry is the unsigned carry out, and overflow is set when the signed sum is out of range. `wr_en`=1 and `flag_upd`=4'b1111.
- R4: Subtract produces dst-src modulo 2^16. Carry is set when dst < src (unsigned borrow), and overflow is set when the signed difference is out of range. `wr_en`=1 and `flag_upd`=4'b1111.
- R5: Compare produces the same result and flags as subtract, with `wr_en`=0 and `flag_upd`=4'b1111.
- R6: AND, OR and XOR produce the bitwise result with carry=0 and overflow=0. `wr_en`=1 and `flag_upd`=4'b1111.
- R7: Test produces dst AND src with the same flags as AND, and with `wr_en`=0.
- R8: Negate produces 0-dst. Carry is 0 only when dst is 0, and overflow is set only when dst is 0x8000. `wr_en`=1 and `flag_upd`=4'b1111.
- R9: Invert produces ~dst with `wr_en`=1 and `flag_upd`=0. `flags_out` equals `flags_in`.
- R10: For every operation that updates flags, zero is set exactly when the result is 0x0000, and sign equals result bit 15.
- R11: Any other operation code gives `wr_en`=0, `flag_upd`=0, `result_out`=0, and `flags_out` equal to `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 6 | Operation select |
| dst_in | input | 16 | Destination operand |
| src_in | input | 16 | Source operand |
| flags_in | input | 4 | Current flags {C,Z,S,V} |
| result_out | output | 16 | Computed result, also driven for compare and test |
| wr_en | output | 1 | Result should be written to the destination |
| flags_out | output | 4 | Next flags {C,Z,S,V} |
| flag_upd | output | 4 | Per-flag mask, 1 where the operation defined the flag |

## Verification
The bench builds the block only at its default width of 16 bits. At that width, exhaustive operand coverage is out of reach. Seeded random operands over all nine operations and some unused codes are therefore combined with directed words that sit on the edges where carry and overflow change: 0x0000, 0x7FFF, 0x8000 and 0xFFFF. Random `flags_in` values expose any flag that invert or an unused code fails to pass through.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [5:0] {
        OPC_ADD  = 6'h02,
        OPC_SUB  = 6'h03,
        OPC_AND  = 6'h04,
        OPC_OR   = 6'h05,
        OPC_TEST = 6'h0B,
        OPC_CMP  = 6'h0C,
        OPC_NEG  = 6'h19,
        OPC_NOT  = 6'h1D,
        OPC_XOR  = 6'h26
    } opc_e;

    typedef enum logic [2:0] {
        FN_NONE,
        FN_ADD,
        FN_SUB,
        FN_NEG,
        FN_AND,
        FN_OR,
        FN_XOR,
        FN_INV
    } fn_e;

    // bit 3 carry, bit 2 zero, bit 1 sign, bit 0 overflow
    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic v;
    } flags_t;

    typedef struct packed {
        fn_e    fn;
        logic   arith;
        logic   wr;
        flags_t upd;
    } ctrl_t;

    function automatic flags_t merge_flags(flags_t mask, flags_t fresh, flags_t old);
        return flags_t'((mask & fresh) | (~mask & old));
    endfunction

endpackage

// File: rtl/flag_alu_decode.sv
module flag_alu_decode
    import flag_alu_pkg::*;
(
    input  logic [5:0] op_code,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '{fn: FN_NONE, arith: 1'b0, wr: 1'b0, upd: 4'b0000};
        case (op_code)
            OPC_ADD:  ctrl = '{fn: FN_ADD, arith: 1'b1, wr: 1'b1, upd: 4'b1111};
            OPC_SUB:  ctrl = '{fn: FN_SUB, arith: 1'b1, wr: 1'b1, upd: 4'b1111};
            OPC_CMP:  ctrl = '{fn: FN_SUB, arith: 1'b1, wr: 1'b0, upd: 4'b1111};
            OPC_NEG:  ctrl = '{fn: FN_NEG, arith: 1'b1, wr: 1'b1, upd: 4'b1111};
            OPC_AND:  ctrl = '{fn: FN_AND, arith: 1'b0, wr: 1'b1, upd: 4'b1111};
            OPC_TEST: ctrl = '{fn: FN_AND, arith: 1'b0, wr: 1'b0, upd: 4'b1111};
            OPC_OR:   ctrl = '{fn: FN_OR,  arith: 1'b0, wr: 1'b1, upd: 4'b1111};
            OPC_XOR:  ctrl = '{fn: FN_XOR, arith: 1'b0, wr: 1'b1, upd: 4'b1111};
            OPC_NOT:  ctrl = '{fn: FN_INV, arith: 1'b0, wr: 1'b1, upd: 4'b0000};
            default:  ;
        endcase
    end
endmodule

// File: rtl/flag_alu_arith.sv
module flag_alu_arith
    import flag_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  fn_e              fn,
    input  logic [WIDTH-1:0] dst,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] sum,
    output logic             carry,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic             invert;
    logic [WIDTH-1:0] opx;
    logic [WIDTH-1:0] opy;
    logic [WIDTH:0]   wide;

    // One adder serves add, subtract and negate; negate is 0 - dst.
    always_comb begin
        invert = (fn == FN_SUB) || (fn == FN_NEG);
        opx    = (fn == FN_NEG) ? '0 : dst;
        opy    = (fn == FN_NEG) ? dst : src;
        opy    = invert ? ~opy : opy;
        wide   = {1'b0, opx} + {1'b0, opy} + {{WIDTH{1'b0}}, invert};
        sum    = wide[MSB:0];
        // after inversion, carry-out low means a borrow occurred
        carry  = invert ? ~wide[WIDTH] : wide[WIDTH];
        ovf    = (opx[MSB] == opy[MSB]) && (sum[MSB] != opx[MSB]);
    end
endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
    import flag_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  fn_e              fn,
    input  logic [WIDTH-1:0] dst,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] res
);
    always_comb begin
        case (fn)
            FN_AND:  res = dst & src;
            FN_OR:   res = dst | src;
            FN_XOR:  res = dst ^ src;
            FN_INV:  res = ~dst;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [5:0]       op_code,
    input  logic [WIDTH-1:0] dst_in,
    input  logic [WIDTH-1:0] src_in,
    input  logic [3:0]       flags_in,
    output logic [WIDTH-1:0] result_out,
    output logic             wr_en,
    output logic [3:0]       flags_out,
    output logic [3:0]       flag_upd
);
    localparam int MSB = WIDTH - 1;

    ctrl_t            ctrl;
    logic [WIDTH-1:0] arith_res;
    logic [WIDTH-1:0] logic_res;
    logic             arith_c;
    logic             arith_v;
    logic [WIDTH-1:0] res_nx;
    flags_t           fresh;
    flags_t           next_flags;

    flag_alu_decode u_dec (
        .op_code (op_code),
        .ctrl    (ctrl)
    );

    flag_alu_arith #(.WIDTH(WIDTH)) u_arith (
        .fn    (ctrl.fn),
        .dst   (dst_in),
        .src   (src_in),
        .sum   (arith_res),
        .carry (arith_c),
        .ovf   (arith_v)
    );

    flag_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .fn  (ctrl.fn),
        .dst (dst_in),
        .src (src_in),
        .res (logic_res)
    );

    always_comb begin
        res_nx     = ctrl.arith ? arith_res : logic_res;
        fresh.c    = ctrl.arith & arith_c;
        fresh.v    = ctrl.arith & arith_v;
        fresh.z    = (res_nx == '0);
        fresh.s    = res_nx[MSB];
        next_flags = merge_flags(ctrl.upd, fresh, flags_t'(flags_in));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_out <= '0;
            wr_en      <= 1'b0;
            flags_out  <= 4'b0000;
            flag_upd   <= 4'b0000;
        end else begin
            result_out <= res_nx;
            wr_en      <= ctrl.wr;
            flags_out  <= next_flags;
            flag_upd   <= ctrl.upd;
        end
    end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [5:0]       op_code,
    input logic [WIDTH-1:0] dst_in,
    input logic [3:0]       flags_in,
    input logic [WIDTH-1:0] result_out,
    input logic             wr_en,
    input logic [3:0]       flags_out,
    input logic [3:0]       flag_upd
);
    logic live_q;
    logic is_logic;
    logic is_known;

    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    always_comb begin
        is_logic = (op_code == 6'h04) || (op_code == 6'h05) ||
                   (op_code == 6'h26) || (op_code == 6'h0B);
        is_known = is_logic || (op_code == 6'h02) || (op_code == 6'h03) ||
                   (op_code == 6'h0C) || (op_code == 6'h19) || (op_code == 6'h1D);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!wr_en && flag_upd == 4'b0000)); // R2
    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst) (live_q && flag_upd[2]) |-> (flags_out[2] == (result_out == '0))); // R10
    AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (rst) (live_q && flag_upd[1]) |-> (flags_out[1] == result_out[WIDTH-1])); // R10
    AST_NO_WRITE_ON_COMPARE: assert property (@(posedge clk) disable iff (rst) (live_q && $past(op_code == 6'h0C || op_code == 6'h0B)) |-> !wr_en); // R5
    AST_LOGIC_CV_CLEAR: assert property (@(posedge clk) disable iff (rst) (live_q && $past(is_logic)) |-> (!flags_out[3] && !flags_out[0])); // R6
    AST_NEG_CARRY: assert property (@(posedge clk) disable iff (rst) (live_q && $past(op_code == 6'h19)) |-> (flags_out[3] == ($past(dst_in) != '0))); // R8
    AST_INVERT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst) (live_q && $past(op_code == 6'h1D)) |-> (flag_upd == 4'b0000 && flags_out == $past(flags_in))); // R9
    AST_UNKNOWN_INERT: assert property (@(posedge clk) disable iff (rst) (live_q && $past(!is_known)) |-> (!wr_en && flag_upd == 4'b0000 && flags_out == $past(flags_in))); // R11
endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_code    (op_code),
    .dst_in     (dst_in),
    .flags_in   (flags_in),
    .result_out (result_out),
    .wr_en      (wr_en),
    .flags_out  (flags_out),
    .flag_upd   (flag_upd)
);

// File: tb/sim_flag_alu.sv
`timescale 1ns/1ps
module sim_flag_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  op_code = '0;
    logic [15:0] dst_in = '0;
    logic [15:0] src_in = '0;
    logic [3:0]  flags_in = '0;
    logic [15:0] result_out;
    logic        wr_en;
    logic [3:0]  flags_out;
    logic [3:0]  flag_upd;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    flag_alu u0 (
        .clk(clk), .rst(rst), .op_code(op_code), .dst_in(dst_in), .src_in(src_in),
        .flags_in(flags_in), .result_out(result_out), .wr_en(wr_en),
        .flags_out(flags_out), .flag_upd(flag_upd)
    );

    typedef struct {
        logic [15:0] r;
        logic        w;
        logic [3:0]  f;
        logic [3:0]  m;
        string       tag;
    } exp_t;

    function automatic exp_t model(logic [5:0] op, logic [15:0] d, logic [15:0] s, logic [3:0] fi);
        exp_t e;
        int sd, ss, sr;
        logic c, v;
        sd = $signed(d); ss = $signed(s);
        c = 0; v = 0;
        e.w = 1; e.m = 4'b1111; e.r = 0;
        case (op)
            6'h02: begin e.tag = "R3"; e.r = d + s; c = (32'(d) + 32'(s)) > 32'hFFFF;
                   sr = sd + ss; v = (sr > 32767) || (sr < -32768); end
            6'h03, 6'h0C: begin e.tag = (op == 6'h03) ? "R4" : "R5"; e.r = d - s; c = d < s;
                   sr = sd - ss; v = (sr > 32767) || (sr < -32768); e.w = (op == 6'h03); end
            6'h19: begin e.tag = "R8"; e.r = 16'(0) - d; c = (d != 0); sr = -sd; v = sr > 32767; end
            6'h04: begin e.tag = "R6"; e.r = d & s; end
            6'h05: begin e.tag = "R6"; e.r = d | s; end
            6'h26: begin e.tag = "R6"; e.r = d ^ s; end
            6'h0B: begin e.tag = "R7"; e.r = d & s; e.w = 0; end
            6'h1D: begin e.tag = "R9"; e.r = ~d; e.m = 4'b0000; end
            default: begin e.tag = "R11"; e.w = 0; e.m = 4'b0000; end
        endcase
        if (e.m == 4'b1111) e.f = {c, (e.r == 16'h0000), e.r[15], v};
        else                e.f = fi;
        return e;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv, string what);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic apply(logic [5:0] op, logic [15:0] d, logic [15:0] s, logic [3:0] fi);
        exp_t e;
        @(negedge clk);
        op_code = op; dst_in = d; src_in = s; flags_in = fi;
        e = model(op, d, s, fi);
        @(posedge clk); #1;
        // R1: registered outputs reflect inputs present at the edge; R10 covered by flag compare
        check(e.tag, 32'(result_out), 32'(e.r), "result");
        check(e.tag, 32'(wr_en), 32'(e.w), "wr_en");
        check(e.tag, 32'(flag_upd), 32'(e.m), "flag_upd");
        check(e.tag, 32'(flags_out), 32'(e.f), "flags(R10)");
    endtask

    initial begin
        logic [5:0] ops [9] = '{6'h02, 6'h03, 6'h04, 6'h05, 6'h0B, 6'h0C, 6'h19, 6'h1D, 6'h26};
        logic [15:0] edges [4] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF};
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R2", 32'({result_out, wr_en, flags_out, flag_upd}), 32'h0, "reset state");
        @(negedge clk); rst = 1'b0;
        // directed corners
        apply(6'h02, 16'h7FFF, 16'h0001, 4'h0);   // R3 signed overflow
        apply(6'h02, 16'hFFFF, 16'h0001, 4'h0);   // R3 carry, zero
        apply(6'h03, 16'h0000, 16'h0001, 4'h0);   // R4 borrow
        apply(6'h03, 16'h8000, 16'h0001, 4'h0);   // R4 overflow
        apply(6'h0C, 16'h1234, 16'h1234, 4'hF);   // R5 equal
        apply(6'h19, 16'h0000, 16'h0000, 4'hF);   // R8 zero operand
        apply(6'h19, 16'h8000, 16'h0000, 4'h0);   // R8 overflow
        apply(6'h0B, 16'hF0F0, 16'h0F0F, 4'hF);   // R7 zero result
        apply(6'h1D, 16'h00FF, 16'h0000, 4'hA);   // R9 flags kept
        apply(6'h3F, 16'h1111, 16'h2222, 4'h5);   // R11
        foreach (ops[i])
            foreach (edges[j])
                foreach (edges[k])
                    apply(ops[i], edges[j], edges[k], 4'(j + k));
        for (int n = 0; n < 3000; n++) begin
            logic [5:0] op;
            op = ($urandom % 10 == 0) ? 6'($urandom) : ops[$urandom % 9];
            apply(op, 16'($urandom), 16'($urandom), 4'($urandom));
        end
        // R2: reset mid-run clears outputs
        @(negedge clk); rst = 1'b1; op_code = 6'h02; dst_in = 16'h1; src_in = 16'h1;
        @(posedge clk); #1;
        check("R2", 32'({result_out, wr_en, flags_out, flag_upd}), 32'h0, "mid-run reset");
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule